// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Controller

This controller sits beside one node's cache in a directory-based, write-invalidate multiprocessor. It serves the processor's load-linked (LL) and store-conditional (SC) requests. It tracks a single reservation, made of one valid flag and one line address. It then decides whether each SC may write. When it has to, it asks the line's home directory for a verdict. The directory and the data path are outside the block. The block only signals outcomes and local line-state changes.

An LL records the reservation. It never asks for ownership: when the line is absent, it only fetches a shared copy. An SC with no matching reservation fails at once. An SC whose reservation holds and whose line is locally exclusive succeeds at once, with no network traffic. Any other SC is sent to the home directory. A verdict of "shared" grants it, upgrades the local copy to exclusive and invalidates the other sharers. Any other verdict refuses it. All addresses are line addresses.

Top module: `llsc_resv_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and no reservation is held. `home_req_valid`, `ll_done`, `sc_done`, `line_update_valid` and `inval_others` are all 0.
- R2: An accepted LL records its line as the reservation. An SC to that line with `line_state`=2 (exclusive), and no clearing event in between, then succeeds.
- R3: An LL never requests ownership. If `line_state`=0 (invalid), it raises `home_req_valid` with `home_req_kind`=0 (fetch shared) on the cycle after acceptance. When the response arrives, it pulses `ll_done` with `line_update_state`=1 (shared). If the line is held (1 or 2), `ll_done` pulses on the cycle after acceptance, with no home request and no line update.
- R4: An SC while no reservation is held, or whose line differs from the reserved line, reports `sc_done`=1 and `sc_ok`=0 on the next cycle, with no home request.
- R5: An SC that hits the reservation with `line_state`=2 reports `sc_done`=1 and `sc_ok`=1 on the next cycle. It makes no home request and no line update.
- R6: An SC that hits the reservation with `line_state` 0 or 1 raises `home_req_valid` with `home_req_kind`=1 (conditional-store check) on the next cycle. It fails if `home_rsp_dir` is 0 (uncached) or 2 (exclusive), with no line update.
- R7: A home verdict of `home_rsp_dir`=1 (shared) completes the SC with `sc_ok`=1. In the same cycle, `line_update_valid` pulses with state 2 (exclusive) and `inval_others` pulses.
- R8: A snoop (invalidation or eviction) on the reserved line clears the reservation. A snoop on any other line leaves it intact.
- R9: Every completed SC clears the reservation, whether it succeeds or fails. A following SC to the same line then fails.
- R10: While a home request is outstanding, `req_ready` is 0 and LL/SC requests are ignored. None of them produces a result or a new home request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor LL/SC request present |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-linked |
| req_line | input | LINE_W | Line address of the request |
| line_state | input | 2 | Local state of the requested line: 0 invalid, 1 shared, 2 exclusive |
| req_ready | output | 1 | Controller can accept a request this cycle |
| snoop_valid | input | 1 | Invalidation or eviction of a local line |
| snoop_line | input | LINE_W | Line address of the snoop |
| home_req_valid | output | 1 | One-cycle request to the home directory |
| home_req_kind | output | 1 | 0 = fetch shared copy, 1 = conditional-store check |
| home_req_line | output | LINE_W | Line address of the home request |
| home_rsp_valid | input | 1 | Home directory response present |
| home_rsp_dir | input | 2 | Directory state seen: 0 uncached, 1 shared, 2 exclusive |
| ll_done | output | 1 | LL completed |
| sc_done | output | 1 | SC completed |
| sc_ok | output | 1 | SC succeeded (valid with sc_done) |
| line_update_valid | output | 1 | Local line state must change |
| line_update_state | output | 2 | New local line state: 1 shared, 2 exclusive |
| inval_others | output | 1 | Other sharers must be invalidated |

## Verification
A vector table sweeps the SC decision across local line states and directory verdicts. The sweep separates three kinds of result: local success, which must produce no network request, home success, which must upgrade the line and invalidate the sharers, and home refusal for uncached or exclusive verdicts. Directed sequences cover the events that end a reservation: snoops on the reserved line and on other lines, an SC to a different line, and a repeated SC after the first has completed. One sequence offers requests while a home fetch is still in flight, to show that they are dropped and that the pending LL still ends as a shared copy.

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic [LINE_W-1:0] req_line,
  input  logic [1:0]        line_state,
  output logic              req_ready,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  output logic              home_req_valid,
  output logic              home_req_kind,
  output logic [LINE_W-1:0] home_req_line,
  input  logic              home_rsp_valid,
  input  logic [1:0]        home_rsp_dir,
  output logic              ll_done,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              line_update_valid,
  output logic [1:0]        line_update_state,
  output logic              inval_others
);
  localparam logic [1:0] LS_INV = 2'd0;
  localparam logic [1:0] LS_SH  = 2'd1;
  localparam logic [1:0] LS_EX  = 2'd2;
  localparam logic [1:0] DIR_SH = 2'd1;

  logic              waiting, pend_sc, resv_valid;
  logic [LINE_W-1:0] resv_line;

  assign req_ready = !waiting;

  wire accept    = req_valid && !waiting;
  wire ll_acc    = accept && !req_is_sc;
  wire sc_acc    = accept && req_is_sc;
  wire resv_hit  = resv_valid && (resv_line == req_line);
  wire sc_remote = resv_hit && (line_state != LS_EX);
  wire rsp_take  = waiting && home_rsp_valid;
  wire snoop_hit = snoop_valid && resv_valid && (snoop_line == resv_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting           <= 1'b0;
      pend_sc           <= 1'b0;
      home_req_valid    <= 1'b0;
      home_req_kind     <= 1'b0;
      home_req_line     <= '0;
      ll_done           <= 1'b0;
      sc_done           <= 1'b0;
      sc_ok             <= 1'b0;
      line_update_valid <= 1'b0;
      line_update_state <= LS_INV;
      inval_others      <= 1'b0;
    end else begin
      home_req_valid    <= 1'b0;
      ll_done           <= 1'b0;
      sc_done           <= 1'b0;
      sc_ok             <= 1'b0;
      line_update_valid <= 1'b0;
      inval_others      <= 1'b0;
      if (sc_acc) begin
        if (sc_remote) begin
          waiting        <= 1'b1;
          pend_sc        <= 1'b1;
          home_req_valid <= 1'b1;
          home_req_kind  <= 1'b1;
          home_req_line  <= req_line;
        end else begin
          sc_done <= 1'b1;
          sc_ok   <= resv_hit;
        end
      end
      if (ll_acc) begin
        if (line_state == LS_INV) begin
          waiting        <= 1'b1;
          pend_sc        <= 1'b0;
          home_req_valid <= 1'b1;
          home_req_kind  <= 1'b0;
          home_req_line  <= req_line;
        end else begin
          ll_done <= 1'b1;
        end
      end
      if (rsp_take) begin
        waiting <= 1'b0;
        if (pend_sc) begin
          sc_done <= 1'b1;
          if (home_rsp_dir == DIR_SH) begin
            sc_ok             <= 1'b1;
            line_update_valid <= 1'b1;
            line_update_state <= LS_EX;
            inval_others      <= 1'b1;
          end
        end else begin
          ll_done           <= 1'b1;
          line_update_valid <= 1'b1;
          line_update_state <= LS_SH;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_line  <= '0;
    end else if (ll_acc) begin
      resv_valid <= 1'b1;
      resv_line  <= req_line;
    end else if ((sc_acc && !sc_remote) || (rsp_take && pend_sc) || snoop_hit) begin
      resv_valid <= 1'b0;
    end
  end

  AST_LL_NEVER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_done && line_update_valid) |-> (line_update_state == LS_SH)); // R3
  AST_SC_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && !resv_hit) |=> (sc_done && !sc_ok && !home_req_valid)); // R4
  AST_SC_LOCAL_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && resv_hit && line_state == LS_EX) |=> (sc_done && sc_ok && !home_req_valid && !line_update_valid)); // R5
  AST_SC_GOES_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && sc_remote) |=> (home_req_valid && home_req_kind && !sc_done)); // R6
  AST_GRANT_UPGRADES: assert property (@(posedge clk) disable iff (!rst_n)
    inval_others |-> (sc_done && sc_ok && line_update_valid && line_update_state == LS_EX)); // R7
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !ll_acc) |=> !resv_valid); // R8
  AST_SC_ENDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && !sc_remote) |=> !resv_valid); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !home_rsp_valid) |=> (!sc_done && !ll_done && !home_req_valid)); // R10
endmodule

// File: tb/llsc_resv_ctrl_tb.sv
`timescale 1ns/1ps
module llsc_resv_ctrl_tb;
  localparam int LW = 26;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_is_sc, snoop_valid, home_rsp_valid;
  logic [LW-1:0] req_line, snoop_line;
  logic [1:0] line_state, home_rsp_dir;
  logic req_ready, home_req_valid, home_req_kind, ll_done, sc_done, sc_ok;
  logic line_update_valid, inval_others;
  logic [LW-1:0] home_req_line;
  logic [1:0] line_update_state;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  llsc_resv_ctrl #(.LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
    .req_line(req_line), .line_state(line_state), .req_ready(req_ready),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line),
    .home_req_valid(home_req_valid), .home_req_kind(home_req_kind),
    .home_req_line(home_req_line), .home_rsp_valid(home_rsp_valid),
    .home_rsp_dir(home_rsp_dir), .ll_done(ll_done), .sc_done(sc_done),
    .sc_ok(sc_ok), .line_update_valid(line_update_valid),
    .line_update_state(line_update_state), .inval_others(inval_others));

  // {line_state[7:6], dir[5:4], goes_home[3], ok[2], upgrade[1], unused[0]}
  localparam logic [7:0] VEC [6] = '{
    8'b10_00_0_1_0_0,
    8'b01_01_1_1_1_0,
    8'b01_00_1_0_0_0,
    8'b01_10_1_0_0_0,
    8'b00_01_1_1_1_0,
    8'b00_10_1_0_0_0
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ll(input logic [LW-1:0] ln, input logic [1:0] ls, input string rq);
    req_valid = 1'b1; req_is_sc = 1'b0; req_line = ln; line_state = ls;
    cyc();
    req_valid = 1'b0;
    if (ls == 2'd0) begin
      check({rq, " ll fetch req"}, {home_req_valid, home_req_kind, ll_done}, 3'b100);
      check({rq, " ll fetch line"}, home_req_line, ln);
      home_rsp_valid = 1'b1; home_rsp_dir = 2'd1;
      cyc();
      home_rsp_valid = 1'b0;
      check({rq, " ll fill shared"}, {ll_done, line_update_valid, line_update_state}, 4'b1101);
    end else begin
      check({rq, " ll local"}, {ll_done, home_req_valid, line_update_valid}, 3'b100);
    end
  endtask

  task automatic do_sc(input logic [LW-1:0] ln, input logic [1:0] ls, input logic [1:0] dir,
                       input bit home, input bit ok, input bit upg, input string rq);
    req_valid = 1'b1; req_is_sc = 1'b1; req_line = ln; line_state = ls;
    cyc();
    req_valid = 1'b0;
    if (home) begin
      check({rq, " sc home req"}, {home_req_valid, home_req_kind, sc_done, req_ready}, 4'b1100);
      home_rsp_valid = 1'b1; home_rsp_dir = dir;
      cyc();
      home_rsp_valid = 1'b0;
    end else begin
      check({rq, " sc no home"}, home_req_valid, 1'b0);
    end
    check({rq, " sc result"}, {sc_done, sc_ok, line_update_valid, inval_others}, {1'b1, ok, upg, upg});
    if (upg) check({rq, " sc upgrade state"}, line_update_state, 2'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_is_sc = 1'b0; req_line = '0; line_state = 2'd0;
    snoop_valid = 1'b0; snoop_line = '0; home_rsp_valid = 1'b0; home_rsp_dir = 2'd0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 reset outputs", {req_ready, home_req_valid, ll_done, sc_done, line_update_valid, inval_others}, 6'b100000);
    do_sc(26'h10, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R1 R4 no reservation");

    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = VEC[i];
      do_ll(26'h100 + i, 2'd1, "R2");
      do_sc(26'h100 + i, v[7:6], v[5:4], v[3], v[2], v[1],
            (v[3] ? (v[2] ? "R7 table" : "R6 table") : "R5 table"));
    end

    do_ll(26'h200, 2'd0, "R3");
    do_sc(26'h200, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, "R2 after fetch");

    do_ll(26'h300, 2'd2, "R3 exclusive held");
    do_sc(26'h301, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R4 other line");
    do_sc(26'h300, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R9 after failed sc");

    do_ll(26'h400, 2'd1, "R8");
    snoop_valid = 1'b1; snoop_line = 26'h401; cyc(); snoop_valid = 1'b0;
    do_sc(26'h400, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, "R8 unrelated snoop");
    do_sc(26'h400, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R9 after good sc");

    do_ll(26'h500, 2'd1, "R8");
    snoop_valid = 1'b1; snoop_line = 26'h500; cyc(); snoop_valid = 1'b0;
    do_sc(26'h500, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R8 matching snoop");

    do_ll(26'h600, 2'd1, "R9");
    do_sc(26'h600, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, "R9 refused");
    do_sc(26'h600, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R9 after refusal");

    req_valid = 1'b1; req_is_sc = 1'b0; req_line = 26'h700; line_state = 2'd0;
    cyc();
    check("R10 fetch issued", {home_req_valid, req_ready}, 2'b10);
    req_is_sc = 1'b1; line_state = 2'd2;
    cyc();
    check("R10 sc dropped", {sc_done, ll_done, home_req_valid, req_ready}, 4'b0000);
    req_is_sc = 1'b0; req_line = 26'h701; line_state = 2'd1;
    cyc();
    check("R10 ll dropped", {sc_done, ll_done, home_req_valid}, 3'b000);
    req_valid = 1'b0; home_rsp_valid = 1'b1; home_rsp_dir = 2'd1;
    cyc();
    home_rsp_valid = 1'b0;
    check("R10 pending ll ends shared", {ll_done, sc_done, line_update_state, req_ready}, 5'b10011);
    cyc();
    check("R10 nothing late", {sc_done, ll_done, home_req_valid}, 3'b000);
    do_sc(26'h700, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, "R10 R2 reservation kept");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule